// File: doc/BRIEF.md
# Exception Entry Unit

This unit sits beside the pipeline of a small 32-bit RISC core and performs the exception entry work normally done by the system-control coprocessor. Whenever the pipeline raises a fault request, the unit takes it on the next rising clock edge. It works out the 5-bit cause code and the handler address from the fault type. In the same edge it updates its status, cause, bad-address, translation-entry-high, context and return-PC registers.

One cycle after the request, the unit presents the handler address together with a single-cycle redirect strobe. All of its architectural registers can be read continuously through output ports. The unit does not contain the translation buffer, the pipeline flush, the interrupt priority logic or the exception-return path. The exception-level flag is cleared only by reset.

Top module: `exc_entry_unit`

## Requirements
- R1: A synchronous active-high reset clears the exception-level flag and all register outputs to zero and drops the redirect strobe. A request presented in a cycle where reset is high changes none of them.
- R2: The fault type input `req_type` is encoded as follows: 0 interrupt, 1 TLB modified, 2 TLB refill, 3 TLB invalid, 4 address error, 5 instruction bus error, 6 data bus error, 7 syscall, 8 breakpoint, 9 reserved instruction, 10 coprocessor unusable, 11 overflow, 12 trap, 13 watch, 14 machine check, 15 cache error. The cause code written to Cause[6:2] is 0, 1, (2/3), (2/3), (4/5), 6, 7, 8, 9, 10, 11, 12, 13, 23, 24, 30 respectively.
- R3: The store flag selects the cause code for address errors (4 for a load, 5 for a store) and for TLB refill and TLB invalid faults (2 for a load, 3 for a store). A TLB modified fault always takes code 1 whatever the flag.
- R4: The handler address is a base plus an offset. The base is `cfg_ebase` when `cfg_bev` is 1 and 0xBFC00200 when it is 0.
- R5: The offset is chosen by fault type. An interrupt uses 0x200 when `cfg_iv` is 1 and 0x000 when it is 0. A TLB refill uses 0x180 when the exception-level flag was already set and 0x000 when it was clear. Every other type uses 0x180.
- R6: Each cycle with an accepted request is followed, one cycle later, by exactly one cycle of `redir_valid` high, carrying the handler address on `redir_pc`. `redir_valid` is low in every other cycle.
- R7: Address-error and all three TLB fault types load `req_vaddr` into BadVAddr. All other types leave BadVAddr unchanged.
- R8: The three TLB fault types write EntryHi and Context. EntryHi[31:13] receives VPN[20:2], EntryHi[12:11] receives VPN[1:0], EntryHi[7:0] receives the ASID, and the other EntryHi bits are zero. Context[22:4] receives VPN[20:2], and the other Context bits are zero. Non-TLB types leave both registers unchanged.
- R9: A coprocessor-unusable fault writes `req_cop` into Cause[29:28]. All other types leave that field unchanged.
- R10: When the exception-level flag is clear, an accepted request loads EPC and the delay-slot bit Cause[31]. EPC takes `req_pc`, or `req_pc` minus 4 when `req_in_delay` is 1, and Cause[31] takes `req_in_delay`. The flag is then set. While the flag is already set, EPC and Cause[31] keep their values. Cause bits other than 31, 29:28 and 6:2 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Fault request present this cycle |
| req_type | input | 4 | Fault type (encoding in R2) |
| req_store | input | 1 | 1 for a store access, 0 for a load |
| req_vaddr | input | 32 | Faulting virtual address |
| req_vpn | input | 21 | Virtual page number of the faulting access |
| req_asid | input | 8 | Address-space identifier of the access |
| req_cop | input | 2 | Coprocessor number for an unusable fault |
| req_pc | input | 32 | PC of the faulting instruction |
| req_in_delay | input | 1 | Faulting instruction sits in a branch delay slot |
| cfg_bev | input | 1 | Base select: 1 uses cfg_ebase |
| cfg_iv | input | 1 | Interrupts use the dedicated 0x200 offset |
| cfg_ebase | input | 32 | Programmable exception base |
| redir_valid | output | 1 | One-cycle redirect strobe |
| redir_pc | output | 32 | Handler address |
| status_exl | output | 1 | Exception-level flag |
| cause_q | output | 32 | Cause register |
| badvaddr_q | output | 32 | Bad virtual address register |
| entryhi_q | output | 32 | Translation entry-high register |
| context_q | output | 32 | Context register |
| epc_q | output | 32 | Exception return PC |

## Verification
The bench builds the unit with its default parameters: 32-bit data, a 21-bit page number and an 8-bit address-space identifier. At these values the VPN2 field reaches the top bit of EntryHi and the extension bits sit directly below it, so any shift or placement error shows in the compared words. Random resets clear the exception-level flag between runs of faults, which gives both the first-entry path (EPC written, refill offset 0) and the nested path (EPC held, refill offset 0x180). The base select and the interrupt-vector select change under random stimulus, so all four base-and-offset combinations are covered.

// File: rtl/exc_pkg.sv
package exc_pkg;

  typedef enum logic [3:0] {
    FT_INT          = 4'd0,
    FT_TLB_MOD      = 4'd1,
    FT_TLB_REFILL   = 4'd2,
    FT_TLB_INVAL    = 4'd3,
    FT_ADDR_ERR     = 4'd4,
    FT_IBUS_ERR     = 4'd5,
    FT_DBUS_ERR     = 4'd6,
    FT_SYSCALL      = 4'd7,
    FT_BREAK        = 4'd8,
    FT_RESV_INSTR   = 4'd9,
    FT_COP_UNUSABLE = 4'd10,
    FT_OVERFLOW     = 4'd11,
    FT_TRAP         = 4'd12,
    FT_WATCH        = 4'd13,
    FT_MCHECK       = 4'd14,
    FT_CACHE_ERR    = 4'd15
  } fault_t;

  typedef enum logic [1:0] {
    OFS_ZERO    = 2'd0,
    OFS_GENERAL = 2'd1,
    OFS_INTVEC  = 2'd2
  } ofs_sel_t;

  typedef struct packed {
    logic [4:0] code;
    ofs_sel_t   ofs;
    logic       wr_bad;
    logic       wr_tlb;
    logic       wr_ce;
  } fault_class_t;

  localparam logic [31:0] BOOT_BASE   = 32'hBFC0_0200;
  localparam logic [31:0] OFS_GEN_VAL = 32'h0000_0180;
  localparam logic [31:0] OFS_INT_VAL = 32'h0000_0200;

endpackage

// File: rtl/exc_classify.sv
module exc_classify
  import exc_pkg::*;
(
  input  fault_t       ftype,
  input  logic         store,
  input  logic         exl,
  input  logic         iv,
  output fault_class_t cls
);

  always_comb begin
    cls        = '0;
    cls.ofs    = OFS_GENERAL;
    unique case (ftype)
      FT_INT: begin
        cls.code = 5'd0;
        cls.ofs  = iv ? OFS_INTVEC : OFS_ZERO;
      end
      FT_TLB_MOD: begin
        cls.code   = 5'd1;
        cls.wr_bad = 1'b1;
        cls.wr_tlb = 1'b1;
      end
      FT_TLB_REFILL: begin
        cls.code   = store ? 5'd3 : 5'd2;
        cls.ofs    = exl ? OFS_GENERAL : OFS_ZERO;
        cls.wr_bad = 1'b1;
        cls.wr_tlb = 1'b1;
      end
      FT_TLB_INVAL: begin
        cls.code   = store ? 5'd3 : 5'd2;
        cls.wr_bad = 1'b1;
        cls.wr_tlb = 1'b1;
      end
      FT_ADDR_ERR: begin
        cls.code   = store ? 5'd5 : 5'd4;
        cls.wr_bad = 1'b1;
      end
      FT_IBUS_ERR:     cls.code = 5'd6;
      FT_DBUS_ERR:     cls.code = 5'd7;
      FT_SYSCALL:      cls.code = 5'd8;
      FT_BREAK:        cls.code = 5'd9;
      FT_RESV_INSTR:   cls.code = 5'd10;
      FT_COP_UNUSABLE: begin
        cls.code  = 5'd11;
        cls.wr_ce = 1'b1;
      end
      FT_OVERFLOW:     cls.code = 5'd12;
      FT_TRAP:         cls.code = 5'd13;
      FT_WATCH:        cls.code = 5'd23;
      FT_MCHECK:       cls.code = 5'd24;
      FT_CACHE_ERR:    cls.code = 5'd30;
      default:         cls.code = 5'd0;
    endcase
  end

endmodule

// File: rtl/exc_vector.sv
module exc_vector
  import exc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            bev,
  input  logic [XLEN-1:0] ebase,
  input  ofs_sel_t        ofs,
  output logic [XLEN-1:0] vec
);

  logic [XLEN-1:0] base;
  logic [XLEN-1:0] offset;

  always_comb begin
    base = bev ? ebase : XLEN'(BOOT_BASE);
    unique case (ofs)
      OFS_ZERO:    offset = '0;
      OFS_INTVEC:  offset = XLEN'(OFS_INT_VAL);
      default:     offset = XLEN'(OFS_GEN_VAL);
    endcase
    vec = base + offset;
  end

endmodule

// File: rtl/exc_cp0_regs.sv
module exc_cp0_regs
  import exc_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int VPN_W  = 21,
  parameter int ASID_W = 8,
  parameter int CE_W   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take,
  input  fault_class_t      cls,
  input  logic [XLEN-1:0]   vaddr,
  input  logic [VPN_W-1:0]  vpn,
  input  logic [ASID_W-1:0] asid,
  input  logic [CE_W-1:0]   cop,
  input  logic [XLEN-1:0]   pc,
  input  logic              in_delay,
  output logic              exl,
  output logic [XLEN-1:0]   cause,
  output logic [XLEN-1:0]   badvaddr,
  output logic [XLEN-1:0]   entryhi,
  output logic [XLEN-1:0]   context_r,
  output logic [XLEN-1:0]   epc
);

  localparam int VPN2_W   = VPN_W - 2;
  localparam int EH_VPN2  = XLEN - VPN2_W;
  localparam int EH_EXT   = EH_VPN2 - 2;
  localparam int CTX_VPN2 = 4;
  localparam int CA_BD    = XLEN - 1;
  localparam int CA_CE    = 28;
  localparam int CA_CODE  = 2;

  logic              exl_q;
  logic              bd_q;
  logic [CE_W-1:0]   ce_q;
  logic [4:0]        code_q;
  logic [XLEN-1:0]   bad_q;
  logic [VPN2_W-1:0] vpn2_q;
  logic [1:0]        ext_q;
  logic [ASID_W-1:0] asid_q;
  logic [VPN2_W-1:0] ctx_vpn2_q;
  logic [XLEN-1:0]   epc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      exl_q      <= 1'b0;
      bd_q       <= 1'b0;
      ce_q       <= '0;
      code_q     <= '0;
      bad_q      <= '0;
      vpn2_q     <= '0;
      ext_q      <= '0;
      asid_q     <= '0;
      ctx_vpn2_q <= '0;
      epc_q      <= '0;
    end else if (take) begin
      code_q <= cls.code;
      exl_q  <= 1'b1;
      if (!exl_q) begin
        bd_q  <= in_delay;
        epc_q <= in_delay ? pc - XLEN'(4) : pc;
      end
      if (cls.wr_ce)  ce_q  <= cop;
      if (cls.wr_bad) bad_q <= vaddr;
      if (cls.wr_tlb) begin
        vpn2_q     <= vpn[VPN_W-1:2];
        ext_q      <= vpn[1:0];
        asid_q     <= asid;
        ctx_vpn2_q <= vpn[VPN_W-1:2];
      end
    end
  end

  always_comb begin
    cause                          = '0;
    cause[CA_BD]                   = bd_q;
    cause[CA_CE +: CE_W]           = ce_q;
    cause[CA_CODE +: 5]            = code_q;
    entryhi                        = '0;
    entryhi[EH_VPN2 +: VPN2_W]     = vpn2_q;
    entryhi[EH_EXT +: 2]           = ext_q;
    entryhi[0 +: ASID_W]           = asid_q;
    context_r                      = '0;
    context_r[CTX_VPN2 +: VPN2_W]  = ctx_vpn2_q;
  end

  assign exl      = exl_q;
  assign badvaddr = bad_q;
  assign epc      = epc_q;

  a_r10_exl_sticky: assert property (@(posedge clk) disable iff (rst)
    exl_q |=> exl_q);

  a_r10_epc_held_when_nested: assert property (@(posedge clk) disable iff (rst)
    exl_q |=> ($stable(epc_q) && $stable(bd_q)));

  a_r9_ce_only_on_cop: assert property (@(posedge clk) disable iff (rst)
    !(take && cls.wr_ce) |=> $stable(ce_q));

  a_r7_bad_only_on_addr: assert property (@(posedge clk) disable iff (rst)
    !(take && cls.wr_bad) |=> $stable(bad_q));

endmodule

// File: rtl/exc_entry_unit.sv
module exc_entry_unit
  import exc_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int VPN_W  = 21,
  parameter int ASID_W = 8,
  parameter int CE_W   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [3:0]        req_type,
  input  logic              req_store,
  input  logic [XLEN-1:0]   req_vaddr,
  input  logic [VPN_W-1:0]  req_vpn,
  input  logic [ASID_W-1:0] req_asid,
  input  logic [CE_W-1:0]   req_cop,
  input  logic [XLEN-1:0]   req_pc,
  input  logic              req_in_delay,
  input  logic              cfg_bev,
  input  logic              cfg_iv,
  input  logic [XLEN-1:0]   cfg_ebase,
  output logic              redir_valid,
  output logic [XLEN-1:0]   redir_pc,
  output logic              status_exl,
  output logic [XLEN-1:0]   cause_q,
  output logic [XLEN-1:0]   badvaddr_q,
  output logic [XLEN-1:0]   entryhi_q,
  output logic [XLEN-1:0]   context_q,
  output logic [XLEN-1:0]   epc_q
);

  fault_class_t    cls;
  logic [XLEN-1:0] vec;
  logic            take;
  logic            exl;

  assign take = req_valid && !rst;

  exc_classify u_classify (
    .ftype (fault_t'(req_type)),
    .store (req_store),
    .exl   (exl),
    .iv    (cfg_iv),
    .cls   (cls)
  );

  exc_vector #(.XLEN(XLEN)) u_vector (
    .bev   (cfg_bev),
    .ebase (cfg_ebase),
    .ofs   (cls.ofs),
    .vec   (vec)
  );

  exc_cp0_regs #(
    .XLEN(XLEN), .VPN_W(VPN_W), .ASID_W(ASID_W), .CE_W(CE_W)
  ) u_regs (
    .clk       (clk),
    .rst       (rst),
    .take      (take),
    .cls       (cls),
    .vaddr     (req_vaddr),
    .vpn       (req_vpn),
    .asid      (req_asid),
    .cop       (req_cop),
    .pc        (req_pc),
    .in_delay  (req_in_delay),
    .exl       (exl),
    .cause     (cause_q),
    .badvaddr  (badvaddr_q),
    .entryhi   (entryhi_q),
    .context_r (context_q),
    .epc       (epc_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      redir_valid <= 1'b0;
      redir_pc    <= '0;
    end else begin
      redir_valid <= req_valid;
      if (req_valid) redir_pc <= vec;
    end
  end

  assign status_exl = exl;

  a_r6_strobe_follows_req: assert property (@(posedge clk) disable iff (rst)
    redir_valid |-> $past(req_valid));

  a_r10_exl_set_on_redirect: assert property (@(posedge clk) disable iff (rst)
    redir_valid |-> status_exl);

  a_r6_pc_stable_when_idle: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> $stable(redir_pc));

endmodule

// File: tb/test_exc_entry_unit.sv
`timescale 1ns/1ps
module test_exc_entry_unit;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [3:0]  req_type = '0;
  logic        req_store = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic [20:0] req_vpn = '0;
  logic [7:0]  req_asid = '0;
  logic [1:0]  req_cop = '0;
  logic [31:0] req_pc = '0;
  logic        req_in_delay = 1'b0;
  logic        cfg_bev = 1'b0;
  logic        cfg_iv = 1'b0;
  logic [31:0] cfg_ebase = 32'h8000_0000;
  logic        redir_valid;
  logic [31:0] redir_pc, cause_q, badvaddr_q, entryhi_q, context_q, epc_q;
  logic        status_exl;

  exc_entry_unit i_exc_entry_unit (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_type(req_type),
    .req_store(req_store), .req_vaddr(req_vaddr), .req_vpn(req_vpn),
    .req_asid(req_asid), .req_cop(req_cop), .req_pc(req_pc),
    .req_in_delay(req_in_delay), .cfg_bev(cfg_bev), .cfg_iv(cfg_iv),
    .cfg_ebase(cfg_ebase), .redir_valid(redir_valid), .redir_pc(redir_pc),
    .status_exl(status_exl), .cause_q(cause_q), .badvaddr_q(badvaddr_q),
    .entryhi_q(entryhi_q), .context_q(context_q), .epc_q(epc_q)
  );

  always #2.5 clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;
  bit done = 0;

  // reference model state
  bit        m_v, m_exl;
  bit [31:0] m_pc, m_cause, m_bad, m_eh, m_ctx, m_epc;

  function automatic int code_of(int t, bit st);
    case (t)
      0: return 0;   1: return 1;
      2: return st ? 3 : 2;  3: return st ? 3 : 2;
      4: return st ? 5 : 4;
      5: return 6;   6: return 7;   7: return 8;   8: return 9;
      9: return 10;  10: return 11; 11: return 12; 12: return 13;
      13: return 23; 14: return 24; default: return 30;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_v = 0; m_exl = 0; m_pc = 0; m_cause = 0; m_bad = 0;
      m_eh = 0; m_ctx = 0; m_epc = 0;
    end else begin
      m_v = req_valid;
      if (req_valid) begin
        int t;
        bit [31:0] off;
        t = req_type;
        if (t == 0)      off = cfg_iv ? 32'h200 : 32'h0;
        else if (t == 2) off = m_exl ? 32'h180 : 32'h0;
        else             off = 32'h180;
        m_pc = (cfg_bev ? cfg_ebase : 32'hBFC00200) + off;
        m_cause[6:2] = 5'(code_of(t, req_store));
        if (t == 10) m_cause[29:28] = req_cop;
        if (!m_exl) begin
          m_cause[31] = req_in_delay;
          m_epc = req_in_delay ? req_pc - 4 : req_pc;
        end
        m_exl = 1;
        if (t >= 1 && t <= 4) m_bad = req_vaddr;
        if (t >= 1 && t <= 3) begin
          m_eh  = {req_vpn[20:2], req_vpn[1:0], 3'b0, req_asid};
          m_ctx = {9'b0, req_vpn[20:2], 4'b0};
        end
      end
    end
  end

  task automatic cmp(string tag, bit [31:0] act, bit [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s t=%0t actual=%h expected=%h", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) if (!done) begin
    cycles++;
    if (rst) begin
      cmp("R1 reset strobe", {31'b0, redir_valid}, {31'b0, m_v});
    end else begin
      cmp("R6 strobe", {31'b0, redir_valid}, {31'b0, m_v});
      if (m_v) cmp("R4 R5 vector", redir_pc, m_pc);
      cmp("R10 exl", {31'b0, status_exl}, {31'b0, m_exl});
      cmp("R2 R3 R9 R10 cause", cause_q, m_cause);
      cmp("R7 badvaddr", badvaddr_q, m_bad);
      cmp("R8 entryhi", entryhi_q, m_eh);
      cmp("R8 context", context_q, m_ctx);
      cmp("R10 epc", epc_q, m_epc);
    end
  end

  task automatic fire(int t, bit st, bit dly);
    @(negedge clk);
    req_valid = 1; req_type = 4'(t); req_store = st; req_in_delay = dly;
    req_vaddr = $urandom; req_vpn = 21'($urandom); req_asid = 8'($urandom);
    req_cop = 2'($urandom); req_pc = {$urandom} & 32'hFFFF_FFFC;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: request during reset ignored
    req_valid = 1; req_type = 4'd4; req_vaddr = 32'hDEAD_BEEF;
    @(negedge clk);
    req_valid = 0; rst = 0;
    @(negedge clk);
    // R2 R3: every type, both store values, fresh exception level
    for (int t = 0; t < 16; t++) begin
      for (int s = 0; s < 2; s++) begin
        do_reset();
        cfg_bev = t[0]; cfg_iv = t[1];
        fire(t, s[0], t[2]);
      end
    end
    // R5 R10: nested refill and nested entries
    do_reset();
    fire(2, 0, 1); fire(2, 1, 0); fire(10, 0, 1); fire(1, 1, 0);
    // random stream with back-to-back requests
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      rst = ($urandom % 40) == 0;
      req_valid = $urandom % 2;
      req_type = 4'($urandom); req_store = $urandom % 2;
      req_in_delay = $urandom % 2; req_vaddr = $urandom;
      req_vpn = 21'($urandom); req_asid = 8'($urandom);
      req_cop = 2'($urandom); req_pc = $urandom;
      if (($urandom % 16) == 0) begin
        cfg_bev = $urandom % 2; cfg_iv = $urandom % 2;
        cfg_ebase = {$urandom} & 32'hFFFF_F000;
      end
    end
    @(negedge clk); rst = 0; req_valid = 0;
    repeat (3) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    wait (cycles > 100000);
    if (!done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule